// File: doc/BRIEF.md
# Burst SPI Master

This block is an SPI master that is programmed through a small word-wide register port. It sends one burst of 1 to 4096 bits while a single chip select is held active. Software first places 32-bit words in an 8-deep transmit queue. It then writes the control word with both the run bit and the enable bit set. The block shifts the bits out on MOSI and gathers the bits arriving on MISO into an 8-deep receive queue. When the burst is over, it releases the chip select and raises a completion flag.

The register port has four word addresses: 0 control, 1 status, 2 transmit data (a write pushes one word), 3 receive data (a read pops one word). Read data is combinational on the address. A pop happens on the clock edge where `reg_rd` is high with address 3.

Top module: `burst_spi_master`

## Requirements
- R1: The control word at address 0 holds: enable in bit 0, master select in bit 1, run in bit 2, clock polarity in bit 4, clock phase in bit 5, chip-select active-high in bit 7, chip-select index in bits 13:12, rate code n in bits 18:16 and burst length minus one in bits 31:20. It reads back exactly what was written, and every other bit reads 0.
- R2: A burst starts only when the control word is written with bit 2 and bit 0 both 1. Bit 2 reads 1 while the burst runs and reads 0 once it completes. Writes to address 0 during a burst have no effect.
- R3: A burst is N = length field + 1 bits, each bit taking one SCLK period. Words leave MSB first. When N is not a multiple of 32, the first word provides only its N mod 32 low-order bits, and every later word provides all 32 bits.
- R4: Received bits are packed in the same grouping. The first receive word holds the leftover bits right-aligned with zero upper bits. Later words are full, and the earliest bit lands in the most significant position.
- R5: SCLK stays high and low for 2<<n input clocks each (period 4<<n).
- R6: Only the selected chip-select output is active, and it stays active for the whole burst. All outputs sit at the inactive level otherwise. The active level is low when bit 7 is 0 and high when bit 7 is 1.
- R7: SCLK idles at the polarity bit. With phase 0, MOSI is valid before the first edge, MISO is sampled on leading edges and MOSI changes on trailing edges. With phase 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R8: The chip select is released half an SCLK period after the last edge. Status bit 7 (complete) is set after that release and is cleared by writing 1 to bit 7.
- R9: A received word that arrives when the receive queue already holds 8 words is dropped, and status bit 6 (overflow) is set. Writing 1 to bit 6 clears it.
- R10: When the transmit queue is empty at the point a word is needed, that word is sent as all zeros.
- R11: Reading address 3 while the receive queue is empty returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 3) |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select outputs |

## Verification
The hardest case to reach is a receive overflow that comes together with a transmit underflow. Both queues are only 8 words deep, so one burst cannot be preloaded past 256 bits. The bench therefore runs a 288-bit burst with 8 words queued and nothing read back. This pushes a ninth received word into a full queue, and the ninth transmit word must go out as zeros. A bench-side slave model captures MOSI and drives MISO on the edges that each mode defines. It also timestamps every SCLK edge and the chip-select release, so the bench can check the leftover-first word packing and the tail delay without any access to internal state.

// File: rtl/burst_spi_pkg.sv
package burst_spi_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 12;
  localparam int RATE_W = 3;
  localparam int SEL_W  = 2;
  localparam int NUM_CS = 1 << SEL_W;
  localparam int ADDR_W = 2;
  localparam int EDGE_W = LEN_W + 1;
  localparam int WBIT_W = $clog2(WORD_W) + 1;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_TXD  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_RXD  = 2'd3;

  localparam int ST_DONE_BIT = 7;
  localparam int ST_OVF_BIT  = 6;

  typedef struct packed {
    logic [LEN_W-1:0]  len_m1;
    logic [RATE_W-1:0] rate;
    logic [SEL_W-1:0]  sel;
    logic              cs_hi;
    logic              cpha;
    logic              cpol;
    logic              master;
    logic              en;
  } spi_cfg_t;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_SETUP,
    ENG_RUN,
    ENG_TAIL,
    ENG_FIN
  } eng_state_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    if (do_push && !do_pop) cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CNT_W = (1 << RATE_W) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  assign limit = (CNT_W'(2) << rate) - CNT_W'(1);
  assign tick  = run && (cnt_q == limit);

  always_comb begin
    if (!run || cnt_q == limit) cnt_d = '0;
    else                        cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import burst_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  spi_cfg_t          cfg,
  input  logic              tick,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_empty,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word,
  input  logic              miso,
  output logic              mosi,
  output logic              sclk,
  output logic              cs_on,
  output logic              div_run,
  output logic              done
);
  eng_state_t        state_q, state_d;
  logic [EDGE_W-1:0] ecnt_q, ecnt_d, last_e;
  logic [WORD_W-1:0] tsr_q, tsr_d, word_in;
  logic [WORD_W-2:0] rsr_q, rsr_d;
  logic [WBIT_W-1:0] txl_q, txl_d, rxl_q, rxl_d, first_w;
  logic [4:0]        rem;
  logic              sclk_q, sclk_d, cs_q, cs_d;
  logic              lead, adv, smp;

  assign rem     = cfg.len_m1[4:0] + 5'd1;
  assign first_w = (rem == 5'd0) ? WBIT_W'(WORD_W) : {1'b0, rem};
  assign last_e  = {cfg.len_m1, 1'b1};
  assign word_in = tx_empty ? '0 : tx_word;
  assign rx_word = {rsr_q, miso};
  assign lead    = ~ecnt_q[0];
  assign adv     = cfg.cpha ? (lead && ecnt_q != '0) : (!lead && ecnt_q != last_e);
  assign smp     = lead ^ cfg.cpha;

  assign mosi    = tsr_q[WORD_W-1];
  assign sclk    = cs_q ? sclk_q : cfg.cpol;
  assign cs_on   = cs_q;
  assign done    = (state_q == ENG_FIN);
  assign div_run = (state_q == ENG_SETUP) || (state_q == ENG_RUN) || (state_q == ENG_TAIL);

  always_comb begin
    state_d = state_q;
    ecnt_d  = ecnt_q;
    tsr_d   = tsr_q;
    rsr_d   = rsr_q;
    txl_d   = txl_q;
    rxl_d   = rxl_q;
    sclk_d  = sclk_q;
    cs_d    = cs_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        sclk_d = cfg.cpol;
        if (start) begin
          state_d = ENG_SETUP;
          cs_d    = 1'b1;
          ecnt_d  = '0;
          tsr_d   = word_in << (WBIT_W'(WORD_W) - first_w);
          txl_d   = first_w;
          rxl_d   = first_w;
          rsr_d   = '0;
          tx_pop  = !tx_empty;
        end
      end
      ENG_SETUP: begin
        sclk_d = cfg.cpol;
        if (tick) state_d = ENG_RUN;
      end
      ENG_RUN: begin
        if (tick) begin
          sclk_d = ~sclk_q;
          if (smp) begin
            rsr_d = rx_word[WORD_W-2:0];
            if (rxl_q == WBIT_W'(1)) begin
              rx_push = 1'b1;
              rxl_d   = WBIT_W'(WORD_W);
            end else begin
              rxl_d = rxl_q - WBIT_W'(1);
            end
          end
          if (adv) begin
            if (txl_q == WBIT_W'(1)) begin
              tsr_d  = word_in;
              tx_pop = !tx_empty;
              txl_d  = WBIT_W'(WORD_W);
            end else begin
              tsr_d = tsr_q << 1;
              txl_d = txl_q - WBIT_W'(1);
            end
          end
          if (ecnt_q == last_e) state_d = ENG_TAIL;
          else                  ecnt_d  = ecnt_q + EDGE_W'(1);
        end
      end
      ENG_TAIL: begin
        if (tick) begin
          cs_d    = 1'b0;
          state_d = ENG_FIN;
        end
      end
      ENG_FIN:  state_d = ENG_IDLE;
      default:  state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      ecnt_q  <= '0;
      tsr_q   <= '0;
      rsr_q   <= '0;
      txl_q   <= '0;
      rxl_q   <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ecnt_q  <= ecnt_d;
      tsr_q   <= tsr_d;
      rsr_q   <= rsr_d;
      txl_q   <= txl_d;
      rxl_q   <= rxl_d;
      sclk_q  <= sclk_d;
      cs_q    <= cs_d;
    end
  end
endmodule

// File: rtl/burst_spi_master.sv
module burst_spi_master
  import burst_spi_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [WORD_W-1:0]     reg_wdata,
  output logic [WORD_W-1:0]     reg_rdata,
  output logic                  spi_sclk,
  output logic                  spi_mosi,
  input  logic                  spi_miso,
  output logic [NUM_CS-1:0]     spi_cs
);
  spi_cfg_t          ctrl_q, ctrl_d;
  logic              xch_q, xch_d, go_q, done_q, done_d, ovf_q, ovf_d;
  logic              ctrl_wr, stat_wr, start;
  logic              tx_push, tx_pop, tx_empty, tx_full;
  logic              rx_push_req, rx_pop, rx_empty, rx_full;
  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic              tick, div_run, cs_on, eng_done;
  logic [WORD_W-1:0] ctrl_rd, stat_rd;

  assign ctrl_wr = reg_wr && (reg_addr == ADR_CTRL) && !xch_q;
  assign stat_wr = reg_wr && (reg_addr == ADR_STAT);
  assign start   = ctrl_wr && reg_wdata[0] && reg_wdata[2];
  assign tx_push = reg_wr && (reg_addr == ADR_TXD) && !tx_full;
  assign rx_pop  = reg_rd && (reg_addr == ADR_RXD);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.len_m1 = reg_wdata[31:20];
      ctrl_d.rate   = reg_wdata[18:16];
      ctrl_d.sel    = reg_wdata[13:12];
      ctrl_d.cs_hi  = reg_wdata[7];
      ctrl_d.cpha   = reg_wdata[5];
      ctrl_d.cpol   = reg_wdata[4];
      ctrl_d.master = reg_wdata[1];
      ctrl_d.en     = reg_wdata[0];
    end
    xch_d  = start ? 1'b1 : (eng_done ? 1'b0 : xch_q);
    done_d = eng_done ? 1'b1 : ((stat_wr && reg_wdata[ST_DONE_BIT]) ? 1'b0 : done_q);
    ovf_d  = (rx_push_req && rx_full) ? 1'b1
           : ((stat_wr && reg_wdata[ST_OVF_BIT]) ? 1'b0 : ovf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      xch_q  <= 1'b0;
      go_q   <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      xch_q  <= xch_d;
      go_q   <= start;
      done_q <= done_d;
      ovf_q  <= ovf_d;
    end
  end

  always_comb begin
    ctrl_rd        = '0;
    ctrl_rd[31:20] = ctrl_q.len_m1;
    ctrl_rd[18:16] = ctrl_q.rate;
    ctrl_rd[13:12] = ctrl_q.sel;
    ctrl_rd[7]     = ctrl_q.cs_hi;
    ctrl_rd[5]     = ctrl_q.cpha;
    ctrl_rd[4]     = ctrl_q.cpol;
    ctrl_rd[2]     = xch_q;
    ctrl_rd[1]     = ctrl_q.master;
    ctrl_rd[0]     = ctrl_q.en;
    stat_rd              = '0;
    stat_rd[ST_DONE_BIT] = done_q;
    stat_rd[ST_OVF_BIT]  = ovf_q;
    case (reg_addr)
      ADR_CTRL: reg_rdata = ctrl_rd;
      ADR_STAT: reg_rdata = stat_rd;
      ADR_RXD:  reg_rdata = rx_empty ? '0 : rx_head;
      default:  reg_rdata = '0;
    endcase
  end

  spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(reg_wdata),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n), .push(rx_push_req), .din(rx_word),
    .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full)
  );

  spi_half_tick #(.RATE_W(RATE_W)) div_i (
    .clk(clk), .rst_n(rst_n), .run(div_run), .rate(ctrl_q.rate), .tick(tick)
  );

  spi_burst_engine eng_i (
    .clk(clk), .rst_n(rst_n), .start(go_q), .cfg(ctrl_q), .tick(tick),
    .tx_word(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .rx_push(rx_push_req), .rx_word(rx_word), .miso(spi_miso),
    .mosi(spi_mosi), .sclk(spi_sclk), .cs_on(cs_on), .div_run(div_run),
    .done(eng_done)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign spi_cs[g] = (cs_on && ctrl_q.sel == SEL_W'(g)) ? ctrl_q.cs_hi : ~ctrl_q.cs_hi;
  end
endmodule

// File: rtl/burst_spi_master_chk.sv
module burst_spi_master_chk
  import burst_spi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] spi_cs,
  input logic              spi_sclk,
  input spi_cfg_t          cfg,
  input logic              busy,
  input logic              cs_on,
  input logic              done_flag,
  input logic              rx_push_req,
  input logic              rx_full,
  input logic              ovf_flag
);
  logic [NUM_CS-1:0] act;
  assign act = cfg.cs_hi ? spi_cs : ~spi_cs;

  AST_SINGLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act) <= 1) else $error("one-hot chip select violated"); // R6

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_on && $past(cs_on)) |-> $stable(spi_cs)) else $error("chip select moved mid-burst"); // R6

  AST_SCLK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |-> (spi_sclk == cfg.cpol)) else $error("sclk not parked"); // R7

  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg)) else $error("control changed while busy"); // R2

  AST_DONE_CS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> (act == '0)) else $error("complete before release"); // R8

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push_req && rx_full) |=> ovf_flag) else $error("overflow not flagged"); // R9
endmodule

bind burst_spi_master burst_spi_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_sclk(spi_sclk),
  .cfg(ctrl_q), .busy(xch_q), .cs_on(cs_on), .done_flag(done_q),
  .rx_push_req(rx_push_req), .rx_full(rx_full), .ovf_flag(ovf_q)
);

// File: tb/burst_spi_master_tb.sv
module burst_spi_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_mosi;
  logic        miso_r = 1'b0;
  logic [3:0]  spi_cs;

  always #2 clk = ~clk;

  burst_spi_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(miso_r), .spi_cs(spi_cs)
  );

  int nvec = 0, nfail = 0;

  bit smiso [0:4095];
  bit smosi [0:4095];
  logic       m_cpol = 0, m_cpha = 0, m_hi = 0, mon_rst = 1;
  logic [1:0] m_sel = 0;
  int  t = 0, edges = 0, last_edge_t = 0, min_iv = 0, max_iv = 0, cs_off_t = 0;
  int  sidx = 0, lidx = 0, others_bad = 0;
  logic prev_act = 0, prev_sclk = 0;

  always @(negedge clk) begin
    logic act, lead;
    t++;
    if (mon_rst) begin
      edges = 0; sidx = 0; lidx = 0; min_iv = 1000000; max_iv = 0;
      others_bad = 0; cs_off_t = 0; last_edge_t = 0; prev_act = 0;
    end else begin
      act = (spi_cs[m_sel] == m_hi);
      for (int j = 0; j < 4; j++)
        if (j != int'(m_sel) && spi_cs[j] != !m_hi) others_bad++;
      if (act && !prev_act) begin
        prev_sclk = spi_sclk;
        lidx = 0;
        if (!m_cpha) begin miso_r = smiso[0]; lidx = 1; end
      end else if (act && spi_sclk != prev_sclk) begin
        lead = (spi_sclk != m_cpol);
        if (edges > 0) begin
          if (t - last_edge_t < min_iv) min_iv = t - last_edge_t;
          if (t - last_edge_t > max_iv) max_iv = t - last_edge_t;
        end
        last_edge_t = t;
        edges++;
        if (lead != m_cpha) begin
          if (sidx < 4096) smosi[sidx] = spi_mosi;
          sidx++;
        end else begin
          if (lidx < 4096) miso_r = smiso[lidx];
          lidx++;
        end
        prev_sclk = spi_sclk;
      end
      if (!act && prev_act) cs_off_t = t;
      prev_act = act;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act_v, input logic [31:0] exp_v);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse_mon();
    @(negedge clk); mon_rst = 1;
    @(negedge clk); @(negedge clk); mon_rst = 0;
  endtask

  task automatic wait_done(output bit seen);
    logic [31:0] v;
    seen = 0;
    for (int k = 0; k < 20000 && !seen; k++) begin
      rd(2'd1, v);
      if (v[7]) seen = 1;
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input int len_m1, input logic [2:0] rate,
      input logic [1:0] sel, input logic hi, input logic cpha, input logic cpol, input logic go);
    logic [31:0] c = '0;
    c[31:20] = len_m1[11:0]; c[18:16] = rate; c[13:12] = sel;
    c[7] = hi; c[5] = cpha; c[4] = cpol; c[2] = go; c[1] = 1'b1; c[0] = 1'b1;
    return c;
  endfunction

  // Burst scenario: R3 R4 R5 R6 R7 R8 R9 R10 checked here
  task automatic do_burst(input string tag, input logic cpol, input logic cpha,
      input logic [1:0] sel, input logic hi, input logic [2:0] rate,
      input int nbits, input int nload, input int seed, input bit meddle);
    logic [31:0] tw [0:15];
    logic [31:0] v, base, expw;
    int r, ng, idx, bad, half;
    bit seen, exp_bit;
    r    = (nbits % 32 == 0) ? 32 : nbits % 32;
    ng   = (nbits + 31) / 32;
    half = 2 << rate;
    for (int k = 0; k < 16; k++) tw[k] = (32'h9E3779B1 * (k + 1 + seed)) ^ (32'h5A17C3E0 >> (k % 7));
    for (int i = 0; i < 4096; i++) smiso[i] = ((i * 13 + seed * 7) % 11) < 5;
    base = mk_ctrl(nbits - 1, rate, sel, hi, cpha, cpol, 1'b0);
    m_cpol = cpol; m_cpha = cpha; m_sel = sel; m_hi = hi;
    wr(2'd0, base);
    for (int k = 0; k < nload; k++) wr(2'd2, tw[k]);
    pulse_mon();
    wr(2'd0, base | 32'h5);
    rd(2'd0, v);
    chk(v[2] == 1'b1, "R2", {tag, " run bit during burst"}, v, base | 32'h4);
    if (meddle) wr(2'd0, 32'h0007_3035);
    wait_done(seen);
    chk(seen, "R8", {tag, " complete flag"}, 32'(seen), 32'd1);
    rd(2'd0, v);
    chk(v == base, "R2", {tag, " control after burst"}, v, base);
    chk(edges == 2 * nbits, "R3", {tag, " sclk edge count"}, edges, 2 * nbits);
    chk(min_iv == half && max_iv == half, "R5", {tag, " half period"}, min_iv, half);
    chk(cs_off_t - last_edge_t == half, "R8", {tag, " release delay"}, cs_off_t - last_edge_t, half);
    chk(others_bad == 0, "R6", {tag, " other selects idle"}, others_bad, 0);
    chk(spi_sclk == cpol, "R7", {tag, " sclk park"}, 32'(spi_sclk), 32'(cpol));
    bad = 0; idx = 0;
    for (int g = 0; g < ng; g++) begin
      for (int b = ((g == 0) ? r : 32) - 1; b >= 0; b--) begin
        exp_bit = (g < nload) ? tw[g][b] : 1'b0;
        if (smosi[idx] != exp_bit) bad++;
        idx++;
      end
    end
    chk(bad == 0, (nload < ng) ? "R10" : "R3", {tag, " mosi bit stream mismatches"}, bad, 0);
    idx = 0;
    for (int g = 0; g < ng; g++) begin
      expw = '0;
      for (int b = 0; b < ((g == 0) ? r : 32); b++) begin
        expw = {expw[30:0], smiso[idx]};
        idx++;
      end
      if (g < 8) begin
        rd(2'd3, v);
        chk(v == expw, "R4", {tag, $sformatf(" rx word %0d", g)}, v, expw);
      end
    end
    rd(2'd3, v);
    chk(v == 32'd0, "R11", {tag, " empty rx read"}, v, 32'd0);
    rd(2'd1, v);
    chk(v[6] == (ng > 8), "R9", {tag, " overflow flag"}, v, {25'd0, 1'b1, (ng > 8), 6'd0});
    wr(2'd1, 32'h40);
    rd(2'd1, v);
    chk(v == 32'h80, "R9", {tag, " overflow w1c leaves complete"}, v, 32'h80);
    wr(2'd1, 32'h80);
    rd(2'd1, v);
    chk(v == 32'h0, "R8", {tag, " complete w1c"}, v, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_rst = 1'b1;
    // R1 R6 reset state
    chk(spi_cs == 4'hF, "R6", "reset selects idle high", {28'd0, spi_cs}, 32'hF);
    chk(spi_sclk == 1'b0, "R7", "reset sclk low", 32'(spi_sclk), 0);
    rd(2'd0, v); chk(v == 0, "R1", "reset control", v, 0);
    rd(2'd1, v); chk(v == 0, "R8", "reset status", v, 0);
    // R1 field layout, R2 no start with enable low
    wr(2'd0, 32'hFFFF_FFFA);
    rd(2'd0, v); chk(v == 32'hFFF7_30B2, "R1", "control readback mask", v, 32'hFFF7_30B2);
    repeat (20) @(negedge clk);
    chk(spi_cs == 4'h0, "R6", "active-high idle level", {28'd0, spi_cs}, 0);
    rd(2'd1, v); chk(v == 0, "R2", "no burst without enable", v, 0);
    wr(2'd0, 32'h0000_0004);
    repeat (40) @(negedge clk);
    rd(2'd0, v); chk(v == 0, "R2", "run bit with enable low ignored", v, 0);
    rd(2'd1, v); chk(v == 0, "R2", "no complete without enable", v, 0);

    do_burst("mode0 64b",  1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 64,  2, 1, 1'b0);
    do_burst("mode3 40b",  1'b1, 1'b1, 2'd2, 1'b1, 3'd2, 40,  2, 2, 1'b0);
    do_burst("mode1 17b",  1'b0, 1'b1, 2'd1, 1'b0, 3'd1, 17,  1, 3, 1'b0);
    do_burst("mode2 1b",   1'b1, 1'b0, 2'd3, 1'b0, 3'd7, 1,   1, 4, 1'b0);
    do_burst("ignore 48b", 1'b0, 1'b0, 2'd1, 1'b1, 3'd1, 48,  2, 5, 1'b1);
    do_burst("ovf 288b",   1'b0, 1'b0, 2'd0, 1'b0, 3'd0, 288, 8, 6, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule